// File: doc/BRIEF.md
# Alignment Traceback Walker

This block recovers an alignment path once a two-dimensional dynamic-programming fill stage has finished. It walks a stored memory of per-cell traceback pointers and turns the path into a stream of moves. Each move is a match/mismatch, an insertion, a deletion or the final end marker. The fill stage supplies the sequence lengths and the best-scoring cells it found. A two-bit mode input then chooses both where the walk begins and what ends it. The four modes are full end-to-end alignment, best local segment, one sequence spanned end to end, and suffix/prefix overlap.

The walk is driven by a small trace state: plain (MM), inside an insertion run (INS) or inside a deletion run (DEL). At each cell the trace state and the pointer read from memory decide the move, how the coordinates shrink and the next trace state. Pointer reads have one cycle of latency, so each move that needs the memory takes two cycles. Moves forced by the matrix edge take one cycle and do not read the memory. The coordinates where the walk began are held on outputs for the rest of the walk.

Top module: `trace_walker`

## Requirements
- R1: Mode 0 (global) starts at (`qry_len`, `ref_len`) and ends at (0,0). On row 0 it emits forced insertions and on column 0 forced deletions, with no memory read.
- R2: Mode 1 (local) starts at (`best_row`, `best_col`). It ends when it reads a pointer with direction END, or when row or column reaches 0.
- R3: Mode 2 (semi-global) starts at (`qry_len`, `bot_col`) and ends when row reaches 0. On column 0 it emits forced deletions.
- R4: Mode 3 (overlap) starts at (`rcol_row`, `ref_len`) when `rcol_score` is greater than `bot_score`, both compared as signed values. Otherwise it starts at (`qry_len`, `bot_col`). It ends when row or column reaches 0.
- R5: A pointer is 5 bits: bits [2:0] direction (0 END, 1 DIAG, 2 UP, 3 LEFT, 4..7 unknown), bit 3 insertion-extend, bit 4 deletion-extend. In state MM, DIAG gives move code 1 (match/mismatch), UP gives code 2 (deletion), LEFT gives code 3 (insertion), and END or an unknown direction gives code 0 (end).
- R6: Match/mismatch decrements row and column, deletion decrements the row only, and insertion decrements the column only.
- R7: With `AFFINE`=1, UP in MM enters DEL when bit 4 is set, and LEFT enters INS when bit 3 is set. In DEL every move is a deletion whatever the direction field, and the walk stays in DEL only while bit 4 is set. INS behaves the same way with insertions and bit 3.
- R8: The end move is always the last entry. `done` rises in the same cycle, `busy` falls, and `done` stays high until the next accepted start.
- R9: `mv_idx` numbers the entries of a walk from 0. No walk exceeds `MAX_QRY`+`MAX_REF`+1 entries.
- R10: Every move that needs the memory follows exactly one `rd_en` cycle. The move appears two cycles after the read, and such moves are spaced two cycles apart.
- R11: A `start` pulse while `busy` is high has no effect on the walk in progress.
- R12: After reset `busy`, `done` and `mv_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | begin a walk (accepted when idle) |
| mode | input | 2 | 0 global, 1 local, 2 semi-global, 3 overlap |
| qry_len | input | RW | query length (rows) |
| ref_len | input | CW | reference length (columns) |
| best_row | input | RW | row of best cell anywhere |
| best_col | input | CW | column of best cell anywhere |
| bot_col | input | CW | column of best cell in bottom row |
| bot_score | input | SCORE_W | score of that bottom-row cell (signed) |
| rcol_row | input | RW | row of best cell in rightmost column |
| rcol_score | input | SCORE_W | score of that rightmost-column cell (signed) |
| rd_en | output | 1 | pointer memory read strobe |
| rd_row | output | RW | read row address |
| rd_col | output | CW | read column address |
| rd_ptr | input | 5 | pointer data, valid one cycle after `rd_en` |
| mv_valid | output | 1 | move entry valid |
| mv_code | output | 2 | 0 end, 1 match/mismatch, 2 deletion, 3 insertion |
| mv_idx | output | IW | entry index within the walk |
| start_row | output | RW | row where the walk began |
| start_col | output | CW | column where the walk began |
| busy | output | 1 | walk in progress |
| done | output | 1 | walk finished |

## Verification
A memory filled with diagonal pointers shows the start cell and stop rule of each mode. Here the stop shows up only as the number of match moves before the end marker. Shallow bottom rows and columns force the global and semi-global walks onto the matrix edge, which separates forced moves from pointer-driven ones. Overlap runs with a higher right-column score, a tie and negative scores show which candidate is picked and that the comparison is signed. Hand-placed UP, LEFT, unknown and extend-flagged pointers tell plain decoding apart from the gap-run states. An all-UP memory at full size drives the stream to its longest length.

// File: rtl/trace_pkg.sv
package trace_pkg;

   localparam int PTR_W = 5;

   typedef enum logic [1:0] {
      MV_END = 2'd0,
      MV_MMI = 2'd1,
      MV_DEL = 2'd2,
      MV_INS = 2'd3
   } move_e;

   typedef enum logic [1:0] {
      TS_MM  = 2'd0,
      TS_INS = 2'd1,
      TS_DEL = 2'd2
   } tstate_e;

   typedef enum logic [1:0] {
      MODE_GLOBAL  = 2'd0,
      MODE_LOCAL   = 2'd1,
      MODE_SEMI    = 2'd2,
      MODE_OVERLAP = 2'd3
   } mode_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOOK = 2'd1,
      PH_WAIT = 2'd2
   } phase_e;

   localparam logic [2:0] DIR_END  = 3'd0;
   localparam logic [2:0] DIR_DIAG = 3'd1;
   localparam logic [2:0] DIR_UP   = 3'd2;
   localparam logic [2:0] DIR_LEFT = 3'd3;

   localparam int PB_INS_EXT = 3;
   localparam int PB_DEL_EXT = 4;

endpackage

// File: rtl/trace_start_sel.sv
module trace_start_sel
   import trace_pkg::*;
#(
   parameter int RW      = 9,
   parameter int CW      = 9,
   parameter int SCORE_W = 16
) (
   input  logic [1:0]         mode,
   input  logic [RW-1:0]      qry_len,
   input  logic [CW-1:0]      ref_len,
   input  logic [RW-1:0]      best_row,
   input  logic [CW-1:0]      best_col,
   input  logic [CW-1:0]      bot_col,
   input  logic [SCORE_W-1:0] bot_score,
   input  logic [RW-1:0]      rcol_row,
   input  logic [SCORE_W-1:0] rcol_score,
   output logic [RW-1:0]      srow,
   output logic [CW-1:0]      scol
);

   logic rcol_wins;

   // signed compare; a tie goes to the bottom-row candidate
   assign rcol_wins = $signed(rcol_score) > $signed(bot_score);

   always_comb begin
      srow = qry_len;
      scol = ref_len;
      case (mode)
         MODE_GLOBAL: begin
            srow = qry_len;
            scol = ref_len;
         end
         MODE_LOCAL: begin
            srow = best_row;
            scol = best_col;
         end
         MODE_SEMI: begin
            srow = qry_len;
            scol = bot_col;
         end
         default: begin
            if (rcol_wins) begin
               srow = rcol_row;
               scol = ref_len;
            end else begin
               srow = qry_len;
               scol = bot_col;
            end
         end
      endcase
   end

endmodule

// File: rtl/trace_bound.sv
module trace_bound
   import trace_pkg::*;
#(
   parameter int RW = 9,
   parameter int CW = 9
) (
   input  logic [1:0]    mode,
   input  logic [RW-1:0] row,
   input  logic [CW-1:0] col,
   output logic          stop,
   output logic          forced,
   output logic [1:0]    forced_mv
);

   logic row_z;
   logic col_z;

   assign row_z = (row == '0);
   assign col_z = (col == '0);

   always_comb begin
      stop      = 1'b0;
      forced    = 1'b0;
      forced_mv = MV_END;
      case (mode)
         MODE_GLOBAL: begin
            stop = row_z && col_z;
            if (!stop && row_z) begin
               forced    = 1'b1;
               forced_mv = MV_INS;
            end else if (!stop && col_z) begin
               forced    = 1'b1;
               forced_mv = MV_DEL;
            end
         end
         MODE_SEMI: begin
            stop = row_z;
            if (!row_z && col_z) begin
               forced    = 1'b1;
               forced_mv = MV_DEL;
            end
         end
         default: begin
            stop = row_z || col_z;
         end
      endcase
   end

endmodule

// File: rtl/trace_step_decode.sv
module trace_step_decode
   import trace_pkg::*;
#(
   parameter bit AFFINE = 1'b1
) (
   input  logic [1:0]       tstate,
   input  logic [PTR_W-1:0] ptr,
   output logic [1:0]       mv,
   output logic [1:0]       nstate,
   output logic             dec_row,
   output logic             dec_col
);

   logic [2:0] dir;
   assign dir = ptr[2:0];

   generate
      if (AFFINE) begin : g_affine
         logic ins_ext;
         logic del_ext;
         assign ins_ext = ptr[PB_INS_EXT];
         assign del_ext = ptr[PB_DEL_EXT];

         always_comb begin
            mv      = MV_END;
            nstate  = TS_MM;
            dec_row = 1'b0;
            dec_col = 1'b0;
            case (tstate)
               TS_DEL: begin
                  mv      = MV_DEL;
                  dec_row = 1'b1;
                  nstate  = del_ext ? TS_DEL : TS_MM;
               end
               TS_INS: begin
                  mv      = MV_INS;
                  dec_col = 1'b1;
                  nstate  = ins_ext ? TS_INS : TS_MM;
               end
               default: begin
                  case (dir)
                     DIR_DIAG: begin
                        mv      = MV_MMI;
                        dec_row = 1'b1;
                        dec_col = 1'b1;
                     end
                     DIR_UP: begin
                        mv      = MV_DEL;
                        dec_row = 1'b1;
                        nstate  = del_ext ? TS_DEL : TS_MM;
                     end
                     DIR_LEFT: begin
                        mv      = MV_INS;
                        dec_col = 1'b1;
                        nstate  = ins_ext ? TS_INS : TS_MM;
                     end
                     default: mv = MV_END;
                  endcase
               end
            endcase
         end
      end else begin : g_linear
         logic [1:0] unused_bits;
         assign unused_bits = ptr[PTR_W-1:3] ^ tstate;

         always_comb begin
            mv      = MV_END;
            nstate  = TS_MM;
            dec_row = 1'b0;
            dec_col = 1'b0;
            case (dir)
               DIR_DIAG: begin
                  mv      = MV_MMI;
                  dec_row = 1'b1;
                  dec_col = 1'b1;
               end
               DIR_UP: begin
                  mv      = MV_DEL;
                  dec_row = 1'b1;
               end
               DIR_LEFT: begin
                  mv      = MV_INS;
                  dec_col = 1'b1;
               end
               default: mv = MV_END;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/trace_walker.sv
module trace_walker
   import trace_pkg::*;
#(
   parameter int MAX_QRY = 256,
   parameter int MAX_REF = 256,
   parameter int SCORE_W = 16,
   parameter bit AFFINE  = 1'b1,
   localparam int RW = $clog2(MAX_QRY + 1),
   localparam int CW = $clog2(MAX_REF + 1),
   localparam int IW = $clog2(MAX_QRY + MAX_REF + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [1:0]         mode,
   input  logic [RW-1:0]      qry_len,
   input  logic [CW-1:0]      ref_len,
   input  logic [RW-1:0]      best_row,
   input  logic [CW-1:0]      best_col,
   input  logic [CW-1:0]      bot_col,
   input  logic [SCORE_W-1:0] bot_score,
   input  logic [RW-1:0]      rcol_row,
   input  logic [SCORE_W-1:0] rcol_score,
   output logic               rd_en,
   output logic [RW-1:0]      rd_row,
   output logic [CW-1:0]      rd_col,
   input  logic [PTR_W-1:0]   rd_ptr,
   output logic               mv_valid,
   output logic [1:0]         mv_code,
   output logic [IW-1:0]      mv_idx,
   output logic [RW-1:0]      start_row,
   output logic [CW-1:0]      start_col,
   output logic               busy,
   output logic               done
);

   // elaboration-time parameter checks
   if (MAX_QRY < 1) begin : g_bad_qry
      $error("MAX_QRY must be at least 1");
   end
   if (MAX_REF < 1) begin : g_bad_ref
      $error("MAX_REF must be at least 1");
   end
   if (SCORE_W < 2) begin : g_bad_score
      $error("SCORE_W must be at least 2");
   end

   logic [1:0]    phase;
   logic [1:0]    mode_q;
   logic [1:0]    tstate;
   logic [RW-1:0] row;
   logic [CW-1:0] col;
   logic [IW-1:0] cnt;

   logic [RW-1:0] srow;
   logic [CW-1:0] scol;
   logic          stop;
   logic          forced;
   logic [1:0]    forced_mv;
   logic [1:0]    dec_mv;
   logic [1:0]    nstate;
   logic          dec_row;
   logic          dec_col;

   trace_start_sel #(
      .RW      (RW),
      .CW      (CW),
      .SCORE_W (SCORE_W)
   ) u_start (
      .mode       (mode),
      .qry_len    (qry_len),
      .ref_len    (ref_len),
      .best_row   (best_row),
      .best_col   (best_col),
      .bot_col    (bot_col),
      .bot_score  (bot_score),
      .rcol_row   (rcol_row),
      .rcol_score (rcol_score),
      .srow       (srow),
      .scol       (scol)
   );

   trace_bound #(
      .RW (RW),
      .CW (CW)
   ) u_bound (
      .mode      (mode_q),
      .row       (row),
      .col       (col),
      .stop      (stop),
      .forced    (forced),
      .forced_mv (forced_mv)
   );

   trace_step_decode #(
      .AFFINE (AFFINE)
   ) u_dec (
      .tstate  (tstate),
      .ptr     (rd_ptr),
      .mv      (dec_mv),
      .nstate  (nstate),
      .dec_row (dec_row),
      .dec_col (dec_col)
   );

   assign busy   = (phase != PH_IDLE);
   assign rd_en  = (phase == PH_LOOK) && !stop && !forced;
   assign rd_row = row;
   assign rd_col = col;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         mode_q    <= MODE_GLOBAL;
         tstate    <= TS_MM;
         row       <= '0;
         col       <= '0;
         cnt       <= '0;
         mv_valid  <= 1'b0;
         mv_code   <= MV_END;
         mv_idx    <= '0;
         start_row <= '0;
         start_col <= '0;
         done      <= 1'b0;
      end else begin
         mv_valid <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  mode_q    <= mode;
                  row       <= srow;
                  col       <= scol;
                  start_row <= srow;
                  start_col <= scol;
                  cnt       <= '0;
                  done      <= 1'b0;
                  tstate    <= TS_MM;
                  phase     <= PH_LOOK;
               end
            end
            PH_LOOK: begin
               if (stop) begin
                  mv_valid <= 1'b1;
                  mv_code  <= MV_END;
                  mv_idx   <= cnt;
                  cnt      <= cnt + IW'(1);
                  done     <= 1'b1;
                  phase    <= PH_IDLE;
               end else if (forced) begin
                  mv_valid <= 1'b1;
                  mv_code  <= forced_mv;
                  mv_idx   <= cnt;
                  cnt      <= cnt + IW'(1);
                  tstate   <= TS_MM;
                  if (forced_mv == MV_INS) col <= col - CW'(1);
                  else                     row <= row - RW'(1);
               end else begin
                  phase <= PH_WAIT;
               end
            end
            PH_WAIT: begin
               mv_valid <= 1'b1;
               mv_code  <= dec_mv;
               mv_idx   <= cnt;
               cnt      <= cnt + IW'(1);
               if (dec_mv == MV_END) begin
                  done  <= 1'b1;
                  phase <= PH_IDLE;
               end else begin
                  if (dec_row) row <= row - RW'(1);
                  if (dec_col) col <= col - CW'(1);
                  tstate <= nstate;
                  phase  <= PH_LOOK;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/trace_walker_chk.sv
module trace_walker_chk #(
   parameter int MAX_QRY = 256,
   parameter int MAX_REF = 256,
   parameter int RW      = 9,
   parameter int CW      = 9,
   parameter int IW      = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [1:0]    mode,
   input logic [RW-1:0] qry_len,
   input logic [CW-1:0] ref_len,
   input logic          busy,
   input logic          done,
   input logic          rd_en,
   input logic          mv_valid,
   input logic [1:0]    mv_code,
   input logic [IW-1:0] mv_idx,
   input logic [RW-1:0] start_row,
   input logic [CW-1:0] start_col
);

   p_global_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && mode == 2'd0) |=>
         (start_row == $past(qry_len) && start_col == $past(ref_len)));

   p_semi_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && mode == 2'd2) |=> (start_row == $past(qry_len)));

   p_end_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mv_valid && mv_code == 2'd0) |-> (done && !busy));

   p_move_in_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mv_valid |-> $past(busy));

   p_idx_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mv_valid |-> (mv_idx <= IW'(MAX_QRY + MAX_REF)));

   p_read_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> (!rd_en ##1 mv_valid));

   p_hold_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(start_row) && $stable(start_col)));

   p_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({busy, done}));

endmodule

bind trace_walker trace_walker_chk #(
   .MAX_QRY (MAX_QRY),
   .MAX_REF (MAX_REF),
   .RW      (RW),
   .CW      (CW),
   .IW      (IW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .mode      (mode),
   .qry_len   (qry_len),
   .ref_len   (ref_len),
   .busy      (busy),
   .done      (done),
   .rd_en     (rd_en),
   .mv_valid  (mv_valid),
   .mv_code   (mv_code),
   .mv_idx    (mv_idx),
   .start_row (start_row),
   .start_col (start_col)
);

// File: tb/test_trace_walker.sv
`timescale 1ns/1ps
module test_trace_walker;

   localparam int MQ = 8;
   localparam int MR = 8;
   localparam int SW = 8;
   localparam int RW = $clog2(MQ + 1);
   localparam int CW = $clog2(MR + 1);
   localparam int IW = $clog2(MQ + MR + 1);

   localparam logic [4:0] P_END   = 5'd0;
   localparam logic [4:0] P_DIAG  = 5'd1;
   localparam logic [4:0] P_UP    = 5'd2;
   localparam logic [4:0] P_LEFT  = 5'd3;
   localparam logic [4:0] P_UNK   = 5'd5;
   localparam logic [4:0] P_UPX   = 5'd18;
   localparam logic [4:0] P_LEFTX = 5'd11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    mode = 2'd0;
   logic [RW-1:0] qry_len = '0;
   logic [CW-1:0] ref_len = '0;
   logic [RW-1:0] best_row = '0;
   logic [CW-1:0] best_col = '0;
   logic [CW-1:0] bot_col = '0;
   logic [SW-1:0] bot_score = '0;
   logic [RW-1:0] rcol_row = '0;
   logic [SW-1:0] rcol_score = '0;
   logic          rd_en;
   logic [RW-1:0] rd_row;
   logic [CW-1:0] rd_col;
   logic [4:0]    rd_ptr = '0;
   logic          mv_valid;
   logic [1:0]    mv_code;
   logic [IW-1:0] mv_idx;
   logic [RW-1:0] start_row;
   logic [CW-1:0] start_col;
   logic          busy;
   logic          done;

   logic [4:0] mem [0:MQ][0:MR];

   int    n_chk = 0;
   int    n_fail = 0;
   int    cyc = 0;
   bit    finished = 1'b0;
   string got = "";
   int    n_got = 0;
   int    reads = 0;
   int    idx_q [0:31];
   int    cyc_q [0:31];

   always #4 clk = ~clk;

   trace_walker #(
      .MAX_QRY (MQ),
      .MAX_REF (MR),
      .SCORE_W (SW),
      .AFFINE  (1'b1)
   ) i_trace_walker (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .mode       (mode),
      .qry_len    (qry_len),
      .ref_len    (ref_len),
      .best_row   (best_row),
      .best_col   (best_col),
      .bot_col    (bot_col),
      .bot_score  (bot_score),
      .rcol_row   (rcol_row),
      .rcol_score (rcol_score),
      .rd_en      (rd_en),
      .rd_row     (rd_row),
      .rd_col     (rd_col),
      .rd_ptr     (rd_ptr),
      .mv_valid   (mv_valid),
      .mv_code    (mv_code),
      .mv_idx     (mv_idx),
      .start_row  (start_row),
      .start_col  (start_col),
      .busy       (busy),
      .done       (done)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rd_en) rd_ptr <= mem[rd_row][rd_col];
   end

   function automatic string code_str(input logic [1:0] c);
      case (c)
         2'd0: return "E";
         2'd1: return "M";
         2'd2: return "D";
         default: return "I";
      endcase
   endfunction

   always @(negedge clk) begin
      if (mv_valid && n_got < 32) begin
         got = {got, code_str(mv_code)};
         idx_q[n_got] = int'(mv_idx);
         cyc_q[n_got] = cyc;
         n_got++;
      end
      if (rd_en) reads++;
   end

   task automatic check(input bit ok, input string req, input string act, input string exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %s expected %s", req, act, exp);
      end
   endtask

   task automatic fill(input logic [4:0] p);
      for (int r = 0; r <= MQ; r++)
         for (int c = 0; c <= MR; c++)
            mem[r][c] = p;
   endtask

   task automatic walk(input logic [1:0] m, input int q, input int r,
                       input int br, input int bc, input int botc, input int bots,
                       input int rcr, input int rcs, input bit poke);
      @(negedge clk);
      mode = m;
      qry_len = RW'(q);
      ref_len = CW'(r);
      best_row = RW'(br);
      best_col = CW'(bc);
      bot_col = CW'(botc);
      bot_score = SW'(bots);
      rcol_row = RW'(rcr);
      rcol_score = SW'(rcs);
      got = "";
      n_got = 0;
      reads = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         @(negedge clk);
         start = 1'b1;
         mode = ~m;
         qry_len = RW'(1);
         ref_len = CW'(1);
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic check_stream(input string req, input string exp, input int srow, input int scol);
      check(got == exp, req, got, exp);
      check(int'(start_row) == srow && int'(start_col) == scol, req,
            $sformatf("start (%0d,%0d)", start_row, start_col),
            $sformatf("start (%0d,%0d)", srow, scol));
      check(done && !busy, {req, " R8 done"}, $sformatf("done=%0b busy=%0b", done, busy), "done=1 busy=0");
   endtask

   // R12
   task automatic t_reset();
      check(!busy && !done && !mv_valid, "R12 reset",
            $sformatf("busy=%0b done=%0b mv_valid=%0b", busy, done, mv_valid), "all 0");
   endtask

   // R1 R5 R6 R10: diagonal walk, read count and spacing
   task automatic t_global_diag();
      fill(P_DIAG);
      walk(2'd0, 4, 4, 0, 0, 0, 0, 0, 0, 1'b0);
      check_stream("R1", "MMMME", 4, 4);
      check(reads == 4, "R10 reads", $sformatf("%0d", reads), "4");
      check(n_got >= 2 && cyc_q[1] - cyc_q[0] == 2, "R10 spacing",
            $sformatf("%0d", cyc_q[1] - cyc_q[0]), "2");
   endtask

   // R1 forced edge moves; R11 start ignored while busy
   task automatic t_global_edge();
      fill(P_DIAG);
      walk(2'd0, 3, 5, 0, 0, 0, 0, 0, 0, 1'b1);
      check_stream("R1 R11", "MMMIIE", 3, 5);
      check(reads == 3, "R1 forced no read", $sformatf("%0d", reads), "3");
   endtask

   // R2 local ends on END pointer
   task automatic t_local();
      fill(P_DIAG);
      mem[3][4] = P_END;
      walk(2'd1, 7, 7, 5, 6, 0, 0, 0, 0, 1'b0);
      check_stream("R2", "MME", 5, 6);
      fill(P_DIAG);
      mem[2][3] = P_LEFT;
      walk(2'd1, 7, 7, 2, 3, 0, 0, 0, 0, 1'b0);
      check_stream("R2 edge", "IMME", 2, 3);
   endtask

   // R3 semi-global
   task automatic t_semi();
      fill(P_DIAG);
      walk(2'd2, 4, 7, 0, 0, 3, 0, 0, 0, 1'b0);
      check_stream("R3", "MMMDE", 4, 3);
   endtask

   // R4 overlap candidate choice
   task automatic t_overlap();
      fill(P_DIAG);
      walk(2'd3, 6, 5, 0, 0, 3, 4, 2, 10, 1'b0);
      check_stream("R4 rcol", "MME", 2, 5);
      walk(2'd3, 6, 5, 0, 0, 3, 7, 2, 7, 1'b0);
      check_stream("R4 tie", "MMME", 6, 3);
      walk(2'd3, 6, 5, 0, 0, 3, -5, 2, -3, 1'b0);
      check_stream("R4 signed", "MME", 2, 5);
   endtask

   // R5 R6 plain decoding, unknown direction
   task automatic t_decode();
      fill(P_DIAG);
      mem[3][3] = P_UP;
      mem[2][3] = P_LEFT;
      mem[2][2] = P_UNK;
      walk(2'd0, 3, 3, 0, 0, 0, 0, 0, 0, 1'b0);
      check_stream("R5 R6", "DIE", 3, 3);
   endtask

   // R7 gap-run states
   task automatic t_affine();
      fill(P_DIAG);
      mem[4][4] = P_UPX;
      mem[3][4] = P_DIAG;
      mem[2][4] = P_LEFTX;
      mem[2][3] = P_LEFTX;
      mem[2][2] = P_DIAG;
      walk(2'd0, 4, 4, 0, 0, 0, 0, 0, 0, 1'b0);
      check_stream("R7", "DDIIIMDE", 4, 4);
   endtask

   // R9 longest stream and indices
   task automatic t_maxlen();
      string exp;
      fill(P_UP);
      walk(2'd0, MQ, MR, 0, 0, 0, 0, 0, 0, 1'b0);
      exp = "";
      for (int i = 0; i < MQ; i++) exp = {exp, "D"};
      for (int i = 0; i < MR; i++) exp = {exp, "I"};
      exp = {exp, "E"};
      check_stream("R9", exp, MQ, MR);
      check(n_got == MQ + MR + 1, "R9 count", $sformatf("%0d", n_got), $sformatf("%0d", MQ + MR + 1));
      check(idx_q[0] == 0 && idx_q[MQ + MR] == MQ + MR, "R9 idx",
            $sformatf("%0d..%0d", idx_q[0], idx_q[MQ + MR]), $sformatf("0..%0d", MQ + MR));
   endtask

   initial begin
      fill(P_DIAG);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_global_diag();
      t_global_edge();
      t_local();
      t_semi();
      t_overlap();
      t_decode();
      t_affine();
      t_maxlen();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      wait (cyc >= 100000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule